// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block manages a parameterised group of general-purpose I/O pins (eight by default). Software configures the pins through a small synchronous register bus. The bus has an address, a write enable, write data, and combinational read data.

Three registers are visible on the bus:

- a direction register;
- an output register, whose bits also select the pull-up for input pins;
- a pin register, which reads back the synchronised pad levels.

A one written to the pin register address inverts the matching output bit. Software can therefore toggle any pin in a single write.

For each pin, the block drives an output enable, an output level and a pull-up enable toward an external pad model. A global pull-up disable input turns every pull-up off at once.

Incoming pad levels pass through a two-stage synchroniser before software can read them. The first stage captures on the falling clock edge and the second on the rising edge.

Because direction and output are written separately, software chooses the intermediate state when it moves a pin between tri-state and driven-high, or between pull-up input and driven-low.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction and output registers are zero, and every output enable, output level and pull-up enable is low.
- R2: A pin's output enable equals its direction bit. Its output level equals its output bit while the direction bit is 1, and is 0 otherwise. Mode pair {direction, output}: 00 tri-state, 01 pull-up input, 10 drive low, 11 drive high.
- R3: A write to address 2 (pin register) inverts each output bit whose write-data bit is 1, whatever the direction bit holds. Bits written 0 are unchanged.
- R4: A pin's pull-up enable is high exactly when its direction bit is 0, its output bit is 1 and the global disable input is low.
- R5: While the global pull-up disable input is high, every pull-up enable is low.
- R6: A read of address 2 returns the synchronised pad levels for all pins, including pins configured as outputs.
- R7: A pad change made between a rising edge and the following falling edge appears on the address 2 read data only after the next rising edge. It does not appear before that edge.
- R8: Address 0 (direction) and address 1 (output) read back their stored values. A write to one of them leaves the other unchanged.
- R9: Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 direction, 1 output, 2 pin |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pud_i | input | 1 | Global pull-up disable |
| pad_in_i | input | 8 | Pad levels seen at the pins |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin driven level |
| pad_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
The assertions check several properties on every cycle:

- the toggle arithmetic of pin-register writes;
- that the direction and output registers hold when they are not addressed;
- that a pull-up is never enabled on a driven pin, and never while the global disable is set;
- that no level is driven on a disabled pin;
- that the second synchroniser stage follows the first one edge later.

Only the bench scenarios show the remaining behaviour:

- the pad-level read-back through the bus;
- the exact cycle in which an external pad change becomes readable;
- the effect of pull-ups on floating pads;
- that the unused address is inert.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_OUT  = 2'd1,
    ADDR_PIN  = 2'd2,
    ADDR_NONE = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
// Falling-edge capture followed by rising-edge capture: half to 1.5 cycle latency.
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) stage1_q <= '0;
    else         stage1_q <= d_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stage2_q <= '0;
    else         stage2_q <= stage1_q;

  assign q_o = stage2_q;

  // R7: second stage takes the first stage's value one rising edge later
  p_sync_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 stage2_q == $past(stage1_q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o
);
  logic [W-1:0] dir_q, out_q;
  logic wr_dir, wr_out, wr_tgl;

  assign wr_dir = we_i && (addr_i == ADDR_DIR);
  assign wr_out = we_i && (addr_i == ADDR_OUT);
  assign wr_tgl = we_i && (addr_i == ADDR_PIN);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     dir_q <= '0;
    else if (wr_dir) dir_q <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     out_q <= '0;
    else if (wr_out) out_q <= wdata_i;
    else if (wr_tgl) out_q <= out_q ^ wdata_i;

  assign dir_o = dir_q;
  assign out_o = out_q;

  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_PIN) |=> out_q == ($past(out_q) ^ $past(wdata_i)));
  p_dir_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_DIR) |=> $stable(dir_q));
  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == ADDR_OUT || addr_i == ADDR_PIN)) |=> $stable(out_q));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] out_i,
  input  logic         pud_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] pu_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      unique case ({dir_i[i], out_i[i]})
        2'b00: begin oe_o[i] = 1'b0; lvl_o[i] = 1'b0; pu_o[i] = 1'b0;   end
        2'b01: begin oe_o[i] = 1'b0; lvl_o[i] = 1'b0; pu_o[i] = !pud_i; end
        2'b10: begin oe_o[i] = 1'b1; lvl_o[i] = 1'b0; pu_o[i] = 1'b0;   end
        default: begin oe_o[i] = 1'b1; lvl_o[i] = 1'b1; pu_o[i] = 1'b0; end
      endcase
    end
  end

  p_pu_not_driven_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & oe_o) == '0);
  p_pud_forces_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pud_i |-> pu_o == '0);
  p_no_lvl_undriven_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o & ~oe_o) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         pud_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_pu_o
);
  logic [W-1:0] dir_q, out_q, pin_s;

  gpio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .dir_o(dir_q), .out_o(out_q)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_s)
  );

  gpio_pad_ctrl #(.W(W)) u_pad (
    .clk_i, .rst_ni, .dir_i(dir_q), .out_i(out_q), .pud_i,
    .oe_o(pad_oe_o), .lvl_o(pad_out_o), .pu_o(pad_pu_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_DIR: rdata_o = dir_q;
      ADDR_OUT: rdata_o = out_q;
      ADDR_PIN: rdata_o = pin_s;
      default:  rdata_o = '0;
    endcase
  end

  p_oe_tracks_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DIR) |=> pad_oe_o == $past(wdata_i));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   addr = '0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         pud = 1'b0;
  logic [W-1:0] pad_lvl, oe, lvl, pu;
  logic [W-1:0] ext_en = '0, ext_val = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // Pad model: driver wins, then external source, then weak pull-up, else reads low.
  assign pad_lvl = (oe & lvl) | (~oe & ext_en & ext_val) | (~oe & ~ext_en & pu);

  gpio_port #(.W(W)) dut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pud_i(pud), .pad_in_i(pad_lvl),
    .pad_oe_o(oe), .pad_out_o(lvl), .pad_pu_o(pu)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Tasks start and end 5 ns after a rising edge.
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #5;
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [W-1:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
    @(posedge clk); #5;
  endtask

  // {we, addr, wdata, pud, exp_oe, exp_out, exp_pu}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h0F, 1'b0, 8'h0F, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'h3C, 1'b0, 8'h0F, 8'h0C, 8'h30},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'h0F, 8'h0C, 8'h00},
    {1'b1, 2'd2, 8'h11, 1'b0, 8'h0F, 8'h0D, 8'h20},
    {1'b1, 2'd2, 8'h00, 1'b0, 8'h0F, 8'h0D, 8'h20},
    {1'b1, 2'd0, 8'hFF, 1'b0, 8'hFF, 8'h2D, 8'h00},
    {1'b1, 2'd2, 8'hC0, 1'b0, 8'hFF, 8'hED, 8'h00}
  };

  initial begin
    #(20 * 10000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_ni = 1'b1;
    @(posedge clk); #5;

    // R1 reset state
    chk("R1 oe", oe, '0);
    chk("R1 out", lvl, '0);
    chk("R1 pu", pu, '0);
    rd("R1 dir", 2'd0, '0);
    rd("R1 outreg", 2'd1, '0);

    // Vector walk: R2 modes, R3 toggles on input and output pins, R4/R5 pull-ups
    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      pud = v[24];
      if (v[35]) wr(v[34:33], v[32:25]);
      else begin @(posedge clk); #5; end
      chk($sformatf("R2 oe vec%0d", i), oe, v[23:16]);
      chk($sformatf("R2/R3 out vec%0d", i), lvl, v[15:8]);
      chk($sformatf("R4/R5 pu vec%0d", i), pu, v[7:0]);
    end

    // R8 read-back; R6 output pins read their pad level
    rd("R8 dir", 2'd0, 8'hFF);
    rd("R8 outreg", 2'd1, 8'hED);
    rd("R6 pin on outputs", 2'd2, 8'hED);

    // R9 unused address
    wr(2'd3, 8'h55);
    rd("R9 read zero", 2'd3, 8'h00);
    rd("R9 dir kept", 2'd0, 8'hFF);
    rd("R9 out kept", 2'd1, 8'hED);

    // R8 direction write leaves output register alone; R4 pull-ups lift floating pads
    wr(2'd0, 8'h00);
    rd("R8 out after dir write", 2'd1, 8'hED);
    chk("R4 pu inputs", pu, 8'hED);
    rd("R6 pin via pull-ups", 2'd2, 8'hED);

    // R5 global disable: pads float low
    pud = 1'b1;
    @(posedge clk); #5;
    chk("R5 pu off", pu, 8'h00);
    rd("R5 pin floats", 2'd2, 8'h00);
    pud = 1'b0;
    @(posedge clk); #5;

    // R7 synchroniser latency: change at P+5
    addr = 2'd2;
    @(posedge clk); #5;
    chk("R7 before", rdata, 8'hED);
    ext_en = 8'hFF; ext_val = 8'h5A;
    #4  chk("R7 same phase", rdata, 8'hED);
    #6  chk("R7 after fall", rdata, 8'hED);
    #10 chk("R7 after rise", rdata, 8'h5A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule